// File: doc/BRIEF.md
# Descriptor Run Validator

This block sits between a descriptor fetcher and a DMA engine. It takes 32-byte descriptors in list order and unpacks each one into a transfer command: source, destination, next-descriptor address, byte length, end-of-packet and completion-interrupt request. The command goes to the engine only after the descriptor passes its checks. A descriptor that fails a check sets a sticky error code, and the channel takes no more descriptors until reset.

Descriptors arrive as runs of adjacent entries. The fetcher supplies the length of each run on a side input, and the block samples it with the first descriptor of the run. Inside a run, the block tracks the position of each descriptor. It checks that the adjacent count falls by one per descriptor and that the stop bit appears only on the final descriptor.

Both data interfaces use valid/ready. A transfer happens on a rising clock edge when valid and ready are both high. The input can be stalled for three reasons: a command is waiting and the engine is not ready, the completion tracker is full, or the block has latched an error. A command that is offered and not taken keeps all of its fields stable until it is taken. The engine reports finished commands in issue order on a one-cycle done strobe. That strobe drives the completion interrupt.

Top module: `desc_chain_checker`

## Requirements
- R1: Descriptor bits are little-endian words: word0 = data[31:0], word1 = data[63:32], source = data[127:64], destination = data[191:128], next address = data[255:192]. A valid descriptor taken on an edge gives cmd_valid_o after that edge. The command carries length = word1[27:0], end-of-packet = word0 bit 4 and interrupt request = word0 bit 1.
- R2: If word0[31:16] is not 16'hAD4B, the block sets error code 1 and issues no command.
- R3: If any reserved bit is non-zero (word0 bits 15:14, word0 bits 2, 3, 5, 6 and 7, or word1 bits 31:28), the block sets error code 2.
- R4: run_len_i (1 to 64) is sampled with the first descriptor of a run. The descriptor at position p (counting from 0) in a run of N descriptors, where p < N-1, must carry adjacent count word0[13:8] = N-2-p. The last descriptor's count is not checked. Any mismatch, or a run length of 0, sets error code 3.
- R5: If stop (word0 bit 0) is set on any descriptor other than the last of its run, the block sets error code 4. Stop on the last descriptor is legal. The descriptor after the last one starts a new run.
- R6: An error is sticky. While it is set, err_o stays high, err_code_o keeps its value, dsc_ready_o is low and no command is issued. When several checks fail on one descriptor, the lowest code wins: magic, then reserved, then count, then stop.
- R7: While cmd_valid_o is high and cmd_ready_i is low, every command field stays stable and dsc_ready_o is low.
- R8: A done_i strobe matches the oldest unfinished command. irq_o is high in that same cycle only if that command requested an interrupt and irq_en_i is high.
- R9: After reset, err_o = 0, err_code_o = 0, cmd_valid_o = 0, irq_o = 0 and dsc_ready_o = 1.
- R10: After OUTSTANDING commands have been issued and none has received done_i, dsc_ready_o is low. The next done_i makes it high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_en_i | input | 1 | Global enable for completion interrupts |
| run_len_i | input | 7 | Descriptor count of the run beginning with this descriptor |
| dsc_valid_i | input | 1 | Descriptor offered |
| dsc_ready_o | output | 1 | Descriptor accepted on this edge when valid |
| dsc_data_i | input | 256 | Raw 32-byte descriptor |
| cmd_valid_o | output | 1 | Command offered to the engine |
| cmd_ready_i | input | 1 | Engine takes the command |
| cmd_src_o | output | 64 | Source address |
| cmd_dst_o | output | 64 | Destination address |
| cmd_nxt_o | output | 64 | Next descriptor address |
| cmd_len_o | output | 28 | Byte count |
| cmd_eop_o | output | 1 | End of packet |
| cmd_irq_req_o | output | 1 | Completion interrupt requested |
| done_i | input | 1 | Engine finished the oldest outstanding command |
| irq_o | output | 1 | Completion interrupt pulse |
| err_o | output | 1 | Sticky error flag |
| err_code_o | output | 3 | 0 none, 1 magic, 2 reserved, 3 count, 4 stop |

## Verification
The bench walks several runs: single-descriptor runs with and without stop, a three-descriptor run whose last count is arbitrary, and a full 28-bit length. A design that checked the count on the last descriptor, or that did not restart the run after its final entry, would report a false error partway through the table. Each error class is injected on its own, and one descriptor is both malformed and misplaced. This catches a wrong error priority and a latch that clears, and it also catches input that keeps flowing after an error. Back-pressure and a full completion tracker are driven directly; a design that lets fields move while stalled, or that overruns the tracker, would show changed commands or an unexpected ready. Interrupts are checked with the enable both on and off, so gating on the wrong command or ignoring the enable gives a wrong pulse.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  localparam logic [15:0] MAGIC = 16'hAD4B;

  typedef enum logic [2:0] {
    ERR_NONE  = 3'd0,
    ERR_MAGIC = 3'd1,
    ERR_RSVD  = 3'd2,
    ERR_COUNT = 3'd3,
    ERR_STOP  = 3'd4
  } err_e;

  typedef struct packed {
    logic [63:0] src;
    logic [63:0] dst;
    logic [63:0] nxt;
    logic [27:0] len;
    logic [5:0]  adj;
    logic        stop;
    logic        irq;
    logic        eop;
    logic        magic_ok;
    logic        rsvd_ok;
  } desc_t;

  function automatic err_e pick_err(input logic magic_ok, input logic rsvd_ok,
                                    input logic count_bad, input logic stop_bad);
    if (!magic_ok)     return ERR_MAGIC;
    else if (!rsvd_ok) return ERR_RSVD;
    else if (count_bad) return ERR_COUNT;
    else if (stop_bad) return ERR_STOP;
    else               return ERR_NONE;
  endfunction
endpackage

// File: rtl/dcc_unpack.sv
module dcc_unpack
  import dcc_pkg::*;
(
  input  logic [255:0] raw_i,
  output desc_t        desc_o
);
  logic [31:0] w0, w1;
  assign w0 = raw_i[31:0];
  assign w1 = raw_i[63:32];

  always_comb begin
    desc_o.src      = raw_i[127:64];
    desc_o.dst      = raw_i[191:128];
    desc_o.nxt      = raw_i[255:192];
    desc_o.len      = w1[27:0];
    desc_o.adj      = w0[13:8];
    desc_o.stop     = w0[0];
    desc_o.irq      = w0[1];
    desc_o.eop      = w0[4];
    desc_o.magic_ok = (w0[31:16] == MAGIC);
    desc_o.rsvd_ok  = (w0[15:14] == 2'b00) && (w0[3:2] == 2'b00) &&
                      (w0[7:5] == 3'b000) && (w1[31:28] == 4'h0);
  end
endmodule

// File: rtl/dcc_run_track.sv
module dcc_run_track #(
  parameter int MAX_RUN = 64,
  localparam int RW = $clog2(MAX_RUN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] run_len_i,
  input  logic [5:0]    adj_i,
  input  logic          stop_i,
  input  logic          adv_i,
  output logic          count_bad_o,
  output logic          stop_bad_o
);
  logic          in_run_q;
  logic [RW-1:0] rem_q;
  logic [RW-1:0] eff_rem;
  logic          is_last;

  assign eff_rem = in_run_q ? rem_q : run_len_i;
  assign is_last = (eff_rem == RW'(1));

  always_comb begin
    count_bad_o = 1'b0;
    if (eff_rem == '0 || eff_rem > RW'(MAX_RUN)) count_bad_o = 1'b1;
    else if (!is_last && ({1'b0, adj_i} != (RW + 1)'(eff_rem - RW'(2))))
      count_bad_o = 1'b1;
  end

  assign stop_bad_o = stop_i && !is_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_run_q <= 1'b0;
      rem_q    <= '0;
    end else if (adv_i) begin
      if (is_last) begin
        in_run_q <= 1'b0;
      end else begin
        in_run_q <= 1'b1;
        rem_q    <= eff_rem - RW'(1);
      end
    end
  end
endmodule

// File: rtl/dcc_irq_track.sv
module dcc_irq_track #(
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push_i,
  input  logic req_i,
  input  logic pop_i,
  output logic head_o,
  output logic empty_o,
  output logic full_o
);
  logic [DEPTH-1:0] req_q;
  logic [PW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q;
  logic             do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign head_o  = req_q[rd_q];
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) begin
        req_q[wr_q] <= req_i;
        wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + PW'(1);
      end
      if (do_pop) rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + PW'(1);
      cnt_q <= cnt_q + CW'(push_i) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/desc_chain_checker.sv
module desc_chain_checker
  import dcc_pkg::*;
#(
  parameter int MAX_RUN     = 64,
  parameter int OUTSTANDING = 4,
  localparam int RW = $clog2(MAX_RUN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_en_i,
  input  logic [RW-1:0] run_len_i,
  input  logic          dsc_valid_i,
  output logic          dsc_ready_o,
  input  logic [255:0]  dsc_data_i,
  output logic          cmd_valid_o,
  input  logic          cmd_ready_i,
  output logic [63:0]   cmd_src_o,
  output logic [63:0]   cmd_dst_o,
  output logic [63:0]   cmd_nxt_o,
  output logic [27:0]   cmd_len_o,
  output logic          cmd_eop_o,
  output logic          cmd_irq_req_o,
  input  logic          done_i,
  output logic          irq_o,
  output logic          err_o,
  output logic [2:0]    err_code_o
);
  desc_t d;
  logic  count_bad, stop_bad;
  logic  trk_head, trk_empty, trk_full;
  logic  take, good;
  err_e  code;
  err_e  err_q;

  dcc_unpack u_unpack (.raw_i(dsc_data_i), .desc_o(d));

  dcc_run_track #(.MAX_RUN(MAX_RUN)) u_run (
    .clk(clk), .rst_n(rst_n), .run_len_i(run_len_i), .adj_i(d.adj),
    .stop_i(d.stop), .adv_i(take && good),
    .count_bad_o(count_bad), .stop_bad_o(stop_bad)
  );

  dcc_irq_track #(.DEPTH(OUTSTANDING)) u_irq (
    .clk(clk), .rst_n(rst_n), .push_i(take && good), .req_i(d.irq),
    .pop_i(done_i), .head_o(trk_head), .empty_o(trk_empty), .full_o(trk_full)
  );

  assign code        = pick_err(d.magic_ok, d.rsvd_ok, count_bad, stop_bad);
  assign good        = (code == ERR_NONE);
  assign err_o       = (err_q != ERR_NONE);
  assign err_code_o  = err_q;
  assign dsc_ready_o = !err_o && !trk_full && (!cmd_valid_o || cmd_ready_i);
  assign take        = dsc_valid_i && dsc_ready_o;
  assign irq_o       = done_i && !trk_empty && trk_head && irq_en_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q         <= ERR_NONE;
      cmd_valid_o   <= 1'b0;
      cmd_src_o     <= '0;
      cmd_dst_o     <= '0;
      cmd_nxt_o     <= '0;
      cmd_len_o     <= '0;
      cmd_eop_o     <= 1'b0;
      cmd_irq_req_o <= 1'b0;
    end else begin
      if (take && !good) err_q <= code;
      if (take && good) begin
        cmd_valid_o   <= 1'b1;
        cmd_src_o     <= d.src;
        cmd_dst_o     <= d.dst;
        cmd_nxt_o     <= d.nxt;
        cmd_len_o     <= d.len;
        cmd_eop_o     <= d.eop;
        cmd_irq_req_o <= d.irq;
      end else if (cmd_ready_i) begin
        cmd_valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/desc_chain_checker_sva.sv
module desc_chain_checker_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        irq_en_i,
  input logic        dsc_ready_o,
  input logic        cmd_valid_o,
  input logic        cmd_ready_i,
  input logic [63:0] cmd_src_o,
  input logic [27:0] cmd_len_o,
  input logic        cmd_irq_req_o,
  input logic        done_i,
  input logic        irq_o,
  input logic        err_o,
  input logic [2:0]  err_code_o
);
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o && $stable(err_code_o));
  a_r6_err_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !dsc_ready_o);
  a_r6_code_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (err_code_o != 3'd0 && err_code_o <= 3'd4));
  a_r7_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_ready_i) |=> cmd_valid_o && $stable(cmd_src_o)
      && $stable(cmd_len_o) && $stable(cmd_irq_req_o));
  a_r7_stall_input: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_ready_i) |-> !dsc_ready_o);
  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> done_i && irq_en_i);
endmodule

bind desc_chain_checker desc_chain_checker_sva u_sva (.*);

// File: tb/desc_chain_checker_tb_top.sv
module desc_chain_checker_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         irq_en_i = 1'b0;
  logic [6:0]   run_len_i = 7'd1;
  logic         dsc_valid_i = 1'b0;
  logic         dsc_ready_o;
  logic [255:0] dsc_data_i = '0;
  logic         cmd_valid_o;
  logic         cmd_ready_i = 1'b1;
  logic [63:0]  cmd_src_o, cmd_dst_o, cmd_nxt_o;
  logic [27:0]  cmd_len_o;
  logic         cmd_eop_o, cmd_irq_req_o;
  logic         done_i = 1'b0;
  logic         irq_o, err_o;
  logic [2:0]   err_code_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  desc_chain_checker dut_i (.*);

  // {word0, word1, run length}
  localparam logic [70:0] VEC [8] = '{
    {32'hAD4B0100, 32'h00000040, 7'd3},
    {32'hAD4B0010, 32'h00001000, 7'd3},
    {32'hAD4B0502, 32'h0FFFFFFF, 7'd3},
    {32'hAD4B0013, 32'h00000001, 7'd1},
    {32'hAD4B0002, 32'h00000200, 7'd2},
    {32'hAD4B0001, 32'h00000000, 7'd2},
    {32'hAD4B3F12, 32'h00ABCDEF, 7'd1},
    {32'hAD4B0000, 32'h00000010, 7'd1}
  };

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [255:0] mk(input logic [31:0] w0, input logic [31:0] w1,
                                      input int i);
    logic [63:0] s, d, n;
    s = {32'h1000_0000 + 32'(i), 32'hC0DE_0000 ^ 32'(i * 16)};
    d = {32'h2000_0000 + 32'(i), 32'h0000_8000 + 32'(i)};
    n = {32'h0, 32'h0004_0000 + 32'(i * 32)};
    return {n, d, s, w1, w0};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    dsc_valid_i = 1'b0;
    done_i = 1'b0;
    cmd_ready_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // called at a negedge, returns at the negedge after the accepting edge
  task automatic send(input logic [255:0] d, input logic [6:0] rl);
    int n;
    n = 0;
    dsc_data_i = d;
    run_len_i = rl;
    dsc_valid_i = 1'b1;
    while (!dsc_ready_o && n < 20) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
    dsc_valid_i = 1'b0;
  endtask

  task automatic pulse_done(input logic exp_irq, input string tag);
    done_i = 1'b1;
    #1;
    chk(irq_o == exp_irq, tag, 64'(irq_o), 64'(exp_irq));
    @(negedge clk);
    done_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [255:0] d;
    logic [27:0]  held_len;
    do_reset();
    // R9 reset state
    chk(err_o == 1'b0 && err_code_o == 3'd0, "R9 err after reset", 64'(err_code_o), 0);
    chk(cmd_valid_o == 1'b0 && irq_o == 1'b0, "R9 cmd/irq after reset", 64'(cmd_valid_o), 0);
    chk(dsc_ready_o == 1'b1, "R9 ready after reset", 64'(dsc_ready_o), 1);

    // table walk: legal runs (R1, R4, R5, R8)
    for (int i = 0; i < 8; i++) begin
      logic [31:0] w0, w1;
      logic        en;
      w0 = VEC[i][70:39];
      w1 = VEC[i][38:7];
      en = (i % 3) != 1;
      irq_en_i = en;
      d = mk(w0, w1, i);
      send(d, VEC[i][6:0]);
      chk(cmd_valid_o == 1'b1 && err_o == 1'b0, "R4 R5 legal descriptor accepted",
          64'(err_code_o), 0);
      chk(cmd_src_o == d[127:64] && cmd_dst_o == d[191:128] && cmd_nxt_o == d[255:192],
          "R1 addresses", cmd_src_o, d[127:64]);
      chk(cmd_len_o == w1[27:0] && cmd_eop_o == w0[4] && cmd_irq_req_o == w0[1],
          "R1 length/flags", 64'(cmd_len_o), 64'(w1[27:0]));
      pulse_done(w0[1] & en, "R8 irq gating");
    end

    // R7 back-pressure
    cmd_ready_i = 1'b0;
    send(mk(32'hAD4B0002, 32'h0000_0777, 20), 7'd1);
    held_len = cmd_len_o;
    chk(dsc_ready_o == 1'b0, "R7 input stalled", 64'(dsc_ready_o), 0);
    repeat (3) @(negedge clk);
    chk(cmd_valid_o && cmd_len_o == 28'h777 && held_len == 28'h777,
        "R7 command held", 64'(cmd_len_o), 64'h777);
    cmd_ready_i = 1'b1;
    @(negedge clk);
    chk(cmd_valid_o == 1'b0, "R7 released", 64'(cmd_valid_o), 0);
    irq_en_i = 1'b1;
    pulse_done(1'b1, "R8 irq after stall");

    // R10 outstanding limit
    do_reset();
    for (int k = 0; k < 4; k++) send(mk(32'hAD4B0000, 32'h10, k), 7'd1);
    chk(dsc_ready_o == 1'b0, "R10 full tracker stalls", 64'(dsc_ready_o), 0);
    irq_en_i = 1'b0;
    pulse_done(1'b0, "R8 enable off");
    chk(dsc_ready_o == 1'b1, "R10 ready after done", 64'(dsc_ready_o), 1);

    // R2 bad magic
    do_reset();
    send(mk(32'hAD4C0000, 32'h10, 0), 7'd1);
    chk(err_o && err_code_o == 3'd1 && !cmd_valid_o, "R2 magic error", 64'(err_code_o), 1);

    // R3 reserved control bit
    do_reset();
    send(mk(32'hAD4B0004, 32'h10, 0), 7'd1);
    chk(err_code_o == 3'd2 && !cmd_valid_o, "R3 reserved ctl", 64'(err_code_o), 2);
    do_reset();
    send(mk(32'hAD4B0000, 32'h1000_0010, 0), 7'd1);
    chk(err_code_o == 3'd2, "R3 reserved length bits", 64'(err_code_o), 2);

    // R4 broken count: run of 3 needs first count 1
    do_reset();
    send(mk(32'hAD4B0000, 32'h10, 0), 7'd3);
    chk(err_code_o == 3'd3 && !cmd_valid_o, "R4 count mismatch", 64'(err_code_o), 3);
    do_reset();
    send(mk(32'hAD4B0000, 32'h10, 0), 7'd0);
    chk(err_code_o == 3'd3, "R4 zero run length", 64'(err_code_o), 3);
    do_reset();
    send(mk(32'hAD4B0100, 32'h10, 0), 7'd3);
    send(mk(32'hAD4B0100, 32'h10, 1), 7'd3);
    chk(err_code_o == 3'd3, "R4 count not decremented", 64'(err_code_o), 3);

    // R5 stop on first of a run of two
    do_reset();
    send(mk(32'hAD4B0001, 32'h10, 0), 7'd2);
    chk(err_code_o == 3'd4 && !cmd_valid_o, "R5 misplaced stop", 64'(err_code_o), 4);

    // R6 stickiness and priority
    repeat (2) @(negedge clk);
    chk(err_o && err_code_o == 3'd4 && !dsc_ready_o, "R6 error sticky", 64'(err_code_o), 4);
    dsc_data_i = mk(32'hAD4B0000, 32'h10, 9);
    run_len_i = 7'd1;
    dsc_valid_i = 1'b1;
    repeat (2) @(negedge clk);
    dsc_valid_i = 1'b0;
    chk(!cmd_valid_o && err_code_o == 3'd4, "R6 no command after error", 64'(cmd_valid_o), 0);
    do_reset();
    send(mk(32'h12340005, 32'hF000_0000, 0), 7'd2);
    chk(err_code_o == 3'd1, "R6 magic has priority", 64'(err_code_o), 1);
    do_reset();
    send(mk(32'hAD4B0081, 32'h10, 0), 7'd2);
    chk(err_code_o == 3'd2, "R6 reserved before stop", 64'(err_code_o), 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule